// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block sits on the command and address path of a registered memory module. On each rising clock edge it captures a bank of input bits and presents them on a fixed 28-bit registered output bus. Two static configuration inputs select how captured bits reach that bus. In the wide mode, 25 bits pass straight through, one output per input. In the fan-out mode, only 14 bits are captured, and each one drives two outputs. One of two output layouts places those output pairs.

Two active-low chip-select inputs gate the outputs. When both are high at a clock edge, the captured data is left unchanged and the outputs hold. When either is low, the outputs follow the inputs. The first chip-select is also registered onto its own output on every edge. Tying the second select low therefore turns the first into an ordinary registered bit.

An active-low reset clears every register and forces all outputs low at once, without waiting for a clock edge. Reset overrides the chip-select gating. The configuration inputs are only changed while reset is asserted.

Top module: `regbuf_top`

## Requirements
- R1: With `cfg_fanout` low (wide mode), after a capturing edge `q_out[i]` equals the captured `d_in[i]` for i in 0..24, and `q_out[27:25]` is 0.
- R2: With `cfg_fanout` high and `cfg_layout` low (layout A), captured bit i (i in 0..13) drives `q_out[i]` and `q_out[i+14]`; `d_in[24:14]` has no effect on any output.
- R3: With `cfg_fanout` high and `cfg_layout` high (layout B), captured bit i (i in 0..13) drives `q_out[2i]` and `q_out[2i+1]`.
- R4: Data is captured only on the rising clock edge; a change of `d_in` between edges leaves `q_out` unchanged.
- R5: When `cs_a_n` and `cs_b_n` are both high at a rising edge, `q_out` keeps its previous value.
- R6: When either `cs_a_n` or `cs_b_n` is low at a rising edge, `q_out` updates from `d_in`.
- R7: Driving `rst_n` low clears `q_out` and `cs_a_q` to 0 immediately, without a clock edge, and keeps them at 0 whatever the chip-selects are.
- R8: If `d_in` is all zero when `rst_n` is released, `q_out` stays 0 on every following edge while `d_in` stays zero.
- R9: `cs_a_q` takes the value of `cs_a_n` on every rising edge, whatever the value of `cs_b_n`; with `cs_b_n` held low, it acts as one more registered data bit.
- R10: In wide mode, `cfg_layout` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| cfg_fanout | input | 1 | Static mode select: 0 = 25-bit 1:1, 1 = 14-bit 1:2 |
| cfg_layout | input | 1 | Static 1:2 layout select: 0 = layout A, 1 = layout B |
| cs_a_n | input | 1 | Active-low chip-select, also registered to `cs_a_q` |
| cs_b_n | input | 1 | Active-low chip-select used only for gating |
| d_in | input | 25 | Data inputs; only bits 13..0 are used in fan-out mode |
| q_out | output | 28 | Registered outputs |
| cs_a_q | output | 1 | Registered copy of `cs_a_n` |

## Verification
On every cycle, assertions check four things. Outputs hold when both selects are high. Outputs follow the previous inputs when a select is low. The paired outputs of each fan-out layout agree, and the upper outputs stay zero in wide mode. Reset leaves the outputs at zero, and `cs_a_q` tracks the select. Only the bench scenarios can show the rest. These include the reset that clears the outputs between clock edges, the clean release from reset with zero data, the fact that `cfg_layout` and the upper data bits have no effect in the modes where they are unused, and the exact bit positions of each layout against an independent model.

// File: rtl/regbuf_pkg.sv
// Package: shared mode type and configuration decode for the registered buffer.
// Assumes the two configuration pins are static outside reset.
package regbuf_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE  = 2'd0,
        MODE_FAN_A = 2'd1,
        MODE_FAN_B = 2'd2
    } fan_mode_e;

    // Map the two configuration pins onto a routing mode.
    function automatic fan_mode_e decode_mode(input logic fanout, input logic layout);
        if (!fanout)
            return MODE_WIDE;
        else if (!layout)
            return MODE_FAN_A;
        else
            return MODE_FAN_B;
    endfunction

endpackage

// File: rtl/regbuf_capture.sv
// Module: regbuf_capture
// Captures the data bank on the rising edge unless both chip-selects are
// high, and registers the first chip-select on every edge.
// Assumes: rst_n is asynchronous active-low and clears all state.
module regbuf_capture #(
    parameter int DATA_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    output logic [DATA_W-1:0] data_q,
    output logic              cs_a_q
);

    logic hold_now;

    // Gating condition: both selects deasserted means keep the old data.
    always_comb begin
        hold_now = cs_a_n && cs_b_n;
    end

    // Data register with select-based hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (!hold_now)
            data_q <= d_in;
    end

    // Chip-select copy, never gated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs_a_q <= 1'b0;
        else
            cs_a_q <= cs_a_n;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n && cs_b_n) |=> $stable(data_q));

    assert_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_a_n || !cs_b_n) |=> (data_q == $past(d_in)));

    assert_cs_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cs_a_q == $past(cs_a_n)));

endmodule

// File: rtl/regbuf_fanout.sv
// Module: regbuf_fanout
// Routes the captured bits onto the fixed output bus for the selected mode:
// 1:1 for the wide mode, or 1:2 with layout A (i, i+HALF_W) or
// layout B (2i, 2i+1).
// Assumes: DATA_W <= 2*HALF_W, and the mode is static outside reset.
module regbuf_fanout
    import regbuf_pkg::*;
#(
    parameter int DATA_W = 25,
    parameter int HALF_W = 14,
    parameter int OUT_W  = 2 * HALF_W
) (
    input  fan_mode_e         mode,
    input  logic [DATA_W-1:0] data_q,
    output logic [OUT_W-1:0]  q_out
);

    localparam int PAD_W = OUT_W - DATA_W;

    logic [OUT_W-1:0] wide_v;
    logic [OUT_W-1:0] fan_a_v;
    logic [OUT_W-1:0] fan_b_v;

    // Wide layout: straight copy with the upper outputs tied low.
    generate
        if (PAD_W > 0) begin : g_pad
            assign wide_v = {{PAD_W{1'b0}}, data_q};
        end else begin : g_nopad
            assign wide_v = data_q[OUT_W-1:0];
        end
    endgenerate

    // Fan-out layouts: each of the low HALF_W bits drives two outputs.
    generate
        for (genvar i = 0; i < HALF_W; i++) begin : g_pair
            assign fan_a_v[i]          = data_q[i];
            assign fan_a_v[i + HALF_W] = data_q[i];
            assign fan_b_v[2*i]        = data_q[i];
            assign fan_b_v[2*i + 1]    = data_q[i];
        end
    endgenerate

    // Pick the layout for the configured mode.
    always_comb begin
        unique case (mode)
            MODE_FAN_A: q_out = fan_a_v;
            MODE_FAN_B: q_out = fan_b_v;
            default:    q_out = wide_v;
        endcase
    end

endmodule

// File: rtl/regbuf_top.sv
// Module: regbuf_top
// Configurable registered command/address buffer: a 25-bit 1:1 register or
// a 14-bit 1:2 register with two output layouts, chip-select output hold,
// and an asynchronous active-low reset that clears all outputs.
// Assumes: cfg_fanout and cfg_layout only change while rst_n is low.
module regbuf_top
    import regbuf_pkg::*;
#(
    parameter int DATA_W = 25,
    parameter int HALF_W = 14,
    parameter int OUT_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fanout,
    input  logic              cfg_layout,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [OUT_W-1:0]  q_out,
    output logic              cs_a_q
);

    fan_mode_e         mode;
    logic [DATA_W-1:0] data_q;
    logic [HALF_W-1:0] even_bits;
    logic [HALF_W-1:0] odd_bits;

    // Static configuration decode.
    always_comb begin
        mode = decode_mode(cfg_fanout, cfg_layout);
    end

    regbuf_capture #(.DATA_W(DATA_W)) capture_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (d_in),
        .cs_a_n (cs_a_n),
        .cs_b_n (cs_b_n),
        .data_q (data_q),
        .cs_a_q (cs_a_q)
    );

    regbuf_fanout #(.DATA_W(DATA_W), .HALF_W(HALF_W), .OUT_W(OUT_W)) fanout_i (
        .mode   (mode),
        .data_q (data_q),
        .q_out  (q_out)
    );

    // Split the output bus into even and odd positions for the layout check.
    always_comb begin
        for (int i = 0; i < HALF_W; i++) begin
            even_bits[i] = q_out[2*i];
            odd_bits[i]  = q_out[2*i + 1];
        end
    end

    assert_wide_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDE && !(cs_a_n && cs_b_n))
        |=> (q_out[DATA_W-1:0] == $past(d_in)));

    assert_wide_upper_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDE) |-> (q_out[OUT_W-1:DATA_W] == '0));

    assert_layout_a_pairs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAN_A) |-> (q_out[HALF_W-1:0] == q_out[OUT_W-1:HALF_W]));

    assert_layout_b_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAN_B) |-> (even_bits == odd_bits));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |-> (q_out == '0 && cs_a_q == 1'b0));

endmodule

// File: tb/regbuf_top_tb_top.sv
// Bench for regbuf_top: a behavioural reference model updated on each
// rising edge and compared with the outputs after every edge and before it.
module regbuf_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fanout = 1'b0;
    logic        cfg_layout = 1'b0;
    logic        cs_a_n = 1'b1;
    logic        cs_b_n = 1'b1;
    logic [24:0] d_in = '0;
    logic [27:0] q_out;
    logic        cs_a_q;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [24:0] m_data = '0;
    logic        m_cs   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbuf_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_fanout (cfg_fanout),
        .cfg_layout (cfg_layout),
        .cs_a_n     (cs_a_n),
        .cs_b_n     (cs_b_n),
        .d_in       (d_in),
        .q_out      (q_out),
        .cs_a_q     (cs_a_q)
    );

    function automatic logic [27:0] expect_q(input logic [24:0] d, input logic fan, input logic lay);
        logic [27:0] r = '0;
        if (!fan) begin
            r[24:0] = d;
        end else begin
            for (int i = 0; i < 14; i++) begin
                if (!lay) begin
                    r[i] = d[i];
                    r[i+14] = d[i];
                end else begin
                    r[2*i] = d[i];
                    r[2*i+1] = d[i];
                end
            end
        end
        return r;
    endfunction

    task automatic check_out(input string tag);
        logic [27:0] exp_q;
        exp_q = expect_q(m_data, cfg_fanout, cfg_layout);
        vectors++;
        if (q_out !== exp_q) begin
            fails++;
            $display("FAIL %s: q_out=%h expected=%h", tag, q_out, exp_q);
        end
        vectors++;
        if (cs_a_q !== m_cs) begin
            fails++;
            $display("FAIL R9: cs_a_q=%b expected=%b", cs_a_q, m_cs);
        end
    endtask

    // One clock: drive at the falling edge, check before and after the rising edge.
    task automatic run_cycle(input logic [24:0] d, input logic a, input logic b, input string tag);
        @(negedge clk);
        d_in = d;
        cs_a_n = a;
        cs_b_n = b;
        #1 check_out("R4");
        @(posedge clk);
        if (rst_n) begin
            if (!(a && b)) m_data = d;
            m_cs = a;
        end
        #1 check_out(tag);
    endtask

    // Reset, set the configuration, release with zero data and watch it stay low.
    task automatic enter_mode(input logic fan, input logic lay);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_data = '0;
        m_cs = 1'b0;
        check_out("R7");
        cfg_fanout = fan;
        cfg_layout = lay;
        run_cycle('0, 1'b0, 1'b0, "R7");
        @(negedge clk);
        d_in = '0;
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) run_cycle('0, 1'b0, 1'b0, "R8");
    endtask

    task automatic traffic(input string mtag);
        for (int k = 0; k < 40; k++) begin
            logic [24:0] d;
            d = 25'($urandom);
            case (k % 4)
                0: run_cycle(d, 1'b0, 1'b0, mtag);
                1: run_cycle(d, 1'b1, 1'b0, "R6");
                2: run_cycle(d, 1'b0, 1'b1, mtag);
                default: run_cycle(d, 1'b1, 1'b1, "R5");
            endcase
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // Reset state (R7).
        #(CLK_PERIOD * 2 + 1);
        check_out("R7");

        // Wide mode (R1), then wide mode with the layout pin set (R10).
        enter_mode(1'b0, 1'b0);
        run_cycle(25'h1FFFFFF, 1'b0, 1'b0, "R1");
        run_cycle(25'h1555555, 1'b0, 1'b0, "R1");
        traffic("R1");
        enter_mode(1'b0, 1'b1);
        run_cycle(25'h1ABCDEF, 1'b0, 1'b0, "R10");
        traffic("R10");

        // Fan-out layout A (R2): upper inputs toggled but must not appear.
        enter_mode(1'b1, 1'b0);
        run_cycle(25'h1FFC000, 1'b0, 1'b0, "R2");
        run_cycle(25'h0002A55, 1'b0, 1'b0, "R2");
        traffic("R2");

        // Fan-out layout B (R3).
        enter_mode(1'b1, 1'b1);
        run_cycle(25'h0000001, 1'b0, 1'b0, "R3");
        run_cycle(25'h0002000, 1'b0, 1'b0, "R3");
        traffic("R3");

        // cs_b_n tied low: cs_a_n is an ordinary registered bit (R9).
        for (int k = 0; k < 8; k++) run_cycle(25'($urandom), k[0], 1'b0, "R9");

        // Asynchronous reset in mid-cycle while gating is active (R7).
        run_cycle(25'h00012AB, 1'b0, 1'b0, "R3");
        @(negedge clk);
        cs_a_n = 1'b1;
        cs_b_n = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        m_data = '0;
        m_cs = 1'b0;
        #1 check_out("R7");
        run_cycle(25'h1FFFFFF, 1'b1, 1'b1, "R7");
        run_cycle(25'h1FFFFFF, 1'b0, 1'b0, "R7");
        @(negedge clk);
        d_in = '0;
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) run_cycle('0, 1'b0, 1'b1, "R8");
        run_cycle(25'h0003FFF, 1'b0, 1'b0, "R6");
        run_cycle(25'h0000000, 1'b1, 1'b1, "R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule